// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage in-order pipeline handles data and control hazards when taken branches and jumps are only known in the Memory stage. It picks bypass sources for the two Execute operands. It detects a load whose result is needed by the instruction right behind it. It produces hold enables for Fetch and Decode and squash controls for the Decode, Execute and Memory pipeline registers.

A control transfer confirmed in Memory always wins over hazards raised by the younger, wrong-path instructions behind it. Stalls are dropped in that cycle, so the program counter takes the new target. The start request of the multi-cycle multiply/divide unit is also gated by the Execute squash, so an instruction being discarded never launches an operation.

The block is purely combinational. Its outputs feed the pipeline register enables and clears, which act on the next clock edge.

Top module: `hazard_ctrl`

## Requirements
- R1: An Execute operand select is 2'b10 (Memory result) when Memory writes a register equal to that source, and Memory wins over Writeback when both match.
- R2: An operand select is 2'b01 (Writeback result) when Writeback writes a register equal to that source and Memory does not match. Otherwise it is 2'b00 (register file).
- R3: A source index of 0 always gives select 2'b00, whatever the later stages write.
- R4: A load-use hazard exists when Execute holds a load with a nonzero destination equal to either Decode source register.
- R5: stall_f and stall_d are each 1 exactly when (load-use hazard OR busy) AND NOT taken_m.
- R6: When taken_m is 1, flush_d, flush_e and flush_m are all 1 and both stalls are 0, even with a load-use hazard or busy present.
- R7: A load-use hazard with taken_m 0 and busy 0 gives flush_e 1 and flush_d, flush_m 0, while Fetch and Decode hold.
- R8: While busy is 1 and taken_m is 0, flush_e is 0, so the multi-cycle instruction stays in Execute.
- R9: mc_start_out equals mc_start_e AND NOT flush_e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_d | input | REG_AW | First source index in Decode |
| rs2_d | input | REG_AW | Second source index in Decode |
| rs1_e | input | REG_AW | First source index in Execute |
| rs2_e | input | REG_AW | Second source index in Execute |
| rd_e | input | REG_AW | Destination index in Execute |
| load_e | input | 1 | Execute instruction is a load |
| rd_m | input | REG_AW | Destination index in Memory |
| regwr_m | input | 1 | Memory instruction writes a register |
| rd_w | input | REG_AW | Destination index in Writeback |
| regwr_w | input | 1 | Writeback instruction writes a register |
| taken_m | input | 1 | Control transfer confirmed taken in Memory |
| mc_busy | input | 1 | Multi-cycle unit is busy |
| mc_start_e | input | 1 | Execute instruction requests a multi-cycle start |
| fwd_a_e | output | 2 | Bypass select, first Execute operand |
| fwd_b_e | output | 2 | Bypass select, second Execute operand |
| stall_f | output | 1 | Hold the Fetch stage / program counter |
| stall_d | output | 1 | Hold the Decode register |
| flush_d | output | 1 | Clear the Decode register |
| flush_e | output | 1 | Clear the Execute register |
| flush_m | output | 1 | Clear the Memory register |
| mc_start_out | output | 1 | Gated start to the multi-cycle unit |

## Verification
The bench uses a two-bit register index, so every index pattern can be enumerated. The bypass sweep covers every Execute source, both later-stage destinations and both write enables. This separates a Memory match, a Writeback match, a double match where priority matters, and the x0 source that must never bypass. The stall sweep crosses every Decode source pair and Execute destination with the load flag, busy, taken and start bits. This separates load-use against either source, a load to x0, busy alone, and a taken branch overriding each hazard, and it shows whether the start is gated by the squash.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic stall_f;
        logic stall_d;
        logic flush_d;
        logic flush_e;
        logic flush_m;
        logic mc_start;
    } pipe_ctl_t;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0]   src,
    input  logic [REG_AW-1:0]   rd_m,
    input  logic                regwr_m,
    input  logic [REG_AW-1:0]   rd_w,
    input  logic                regwr_w,
    output hazard_pkg::fwd_sel_e sel
);
    import hazard_pkg::*;

    logic src_live;
    logic hit_m;
    logic hit_w;

    always_comb begin
        src_live = (src != '0);
        hit_m    = src_live && regwr_m && (rd_m == src);
        hit_w    = src_live && regwr_w && (rd_w == src);
        if (hit_m)      sel = FWD_MEM;
        else if (hit_w) sel = FWD_WB;
        else            sel = FWD_RF;
    end

    // R3: a bypass is only chosen for a live source register
    always_comb begin
        a_r3_no_x0_bypass: assert (sel == FWD_RF || src != '0)
            else $error("bypass chosen for x0");
    end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rs1_d,
    input  logic [REG_AW-1:0] rs2_d,
    input  logic [REG_AW-1:0] rd_e,
    input  logic              load_e,
    output logic              lu_hazard
);
    logic dst_live;
    logic any_match;

    always_comb begin
        dst_live  = (rd_e != '0);
        any_match = (rd_e == rs1_d) || (rd_e == rs2_d);
        lu_hazard = load_e && dst_live && any_match;
    end
endmodule

// File: rtl/hz_stall_flush.sv
module hz_stall_flush (
    input  logic                  lu_hazard,
    input  logic                  mc_busy,
    input  logic                  taken_m,
    input  logic                  mc_start_e,
    output hazard_pkg::pipe_ctl_t ctl
);
    import hazard_pkg::*;

    logic hold_req;
    logic bubble;

    always_comb begin
        hold_req     = (lu_hazard || mc_busy) && !taken_m;
        bubble       = lu_hazard && !mc_busy && !taken_m;
        ctl.stall_f  = hold_req;
        ctl.stall_d  = hold_req;
        ctl.flush_d  = taken_m;
        ctl.flush_m  = taken_m;
        ctl.flush_e  = taken_m || bubble;
        ctl.mc_start = mc_start_e && !ctl.flush_e;
    end

    // R6: a confirmed transfer never leaves a stall standing
    always_comb begin
        a_r6_taken_beats_stall: assert (!taken_m || (!ctl.stall_f && !ctl.stall_d && ctl.flush_e))
            else $error("stall survived a taken transfer");
    end
    // R8: a busy multi-cycle instruction is not squashed without a transfer
    always_comb begin
        a_r8_busy_keeps_exec: assert (!(mc_busy && !taken_m) || !ctl.flush_e)
            else $error("busy instruction flushed");
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rs1_d,
    input  logic [REG_AW-1:0] rs2_d,
    input  logic [REG_AW-1:0] rs1_e,
    input  logic [REG_AW-1:0] rs2_e,
    input  logic [REG_AW-1:0] rd_e,
    input  logic              load_e,
    input  logic [REG_AW-1:0] rd_m,
    input  logic              regwr_m,
    input  logic [REG_AW-1:0] rd_w,
    input  logic              regwr_w,
    input  logic              taken_m,
    input  logic              mc_busy,
    input  logic              mc_start_e,
    output logic [1:0]        fwd_a_e,
    output logic [1:0]        fwd_b_e,
    output logic              stall_f,
    output logic              stall_d,
    output logic              flush_d,
    output logic              flush_e,
    output logic              flush_m,
    output logic              mc_start_out
);
    import hazard_pkg::*;

    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0] src_e [NUM_SRC];
    fwd_sel_e          sel_e [NUM_SRC];
    logic              lu_hazard;
    pipe_ctl_t         ctl;

    assign src_e[0] = rs1_e;
    assign src_e[1] = rs2_e;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hz_fwd_sel #(.REG_AW(REG_AW)) u_sel (
            .src     (src_e[i]),
            .rd_m    (rd_m),
            .regwr_m (regwr_m),
            .rd_w    (rd_w),
            .regwr_w (regwr_w),
            .sel     (sel_e[i])
        );
    end

    hz_loaduse #(.REG_AW(REG_AW)) u_lu (
        .rs1_d     (rs1_d),
        .rs2_d     (rs2_d),
        .rd_e      (rd_e),
        .load_e    (load_e),
        .lu_hazard (lu_hazard)
    );

    hz_stall_flush u_sf (
        .lu_hazard  (lu_hazard),
        .mc_busy    (mc_busy),
        .taken_m    (taken_m),
        .mc_start_e (mc_start_e),
        .ctl        (ctl)
    );

    always_comb begin
        fwd_a_e      = sel_e[0];
        fwd_b_e      = sel_e[1];
        stall_f      = ctl.stall_f;
        stall_d      = ctl.stall_d;
        flush_d      = ctl.flush_d;
        flush_e      = ctl.flush_e;
        flush_m      = ctl.flush_m;
        mc_start_out = ctl.mc_start;
    end

    // R9: a launched operation always traces back to an Execute request
    always_comb begin
        a_r9_start_has_request: assert (!mc_start_out || (mc_start_e && !flush_e))
            else $error("start without live request");
    end
    // R1: a Memory bypass needs a register write in Memory
    always_comb begin
        a_r1_mem_needs_write: assert (fwd_a_e != FWD_MEM || (regwr_m && rd_m == rs1_e))
            else $error("memory bypass without matching write");
    end
endmodule

// File: tb/hazard_ctrl_test.sv
module hazard_ctrl_test;
    localparam int AW = 2;
    localparam int NR = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] rs1_d, rs2_d, rs1_e, rs2_e, rd_e, rd_m, rd_w;
    logic load_e, regwr_m, regwr_w, taken_m, mc_busy, mc_start_e;
    logic [1:0] fwd_a_e, fwd_b_e;
    logic stall_f, stall_d, flush_d, flush_e, flush_m, mc_start_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hazard_ctrl #(.REG_AW(AW)) uut (
        .rs1_d(rs1_d), .rs2_d(rs2_d), .rs1_e(rs1_e), .rs2_e(rs2_e),
        .rd_e(rd_e), .load_e(load_e), .rd_m(rd_m), .regwr_m(regwr_m),
        .rd_w(rd_w), .regwr_w(regwr_w), .taken_m(taken_m), .mc_busy(mc_busy),
        .mc_start_e(mc_start_e), .fwd_a_e(fwd_a_e), .fwd_b_e(fwd_b_e),
        .stall_f(stall_f), .stall_d(stall_d), .flush_d(flush_d),
        .flush_e(flush_e), .flush_m(flush_m), .mc_start_out(mc_start_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_sel(int src, int rm, int wm, int rw, int ww);
        if (src != 0 && wm != 0 && rm == src) return 2;
        if (src != 0 && ww != 0 && rw == src) return 1;
        return 0;
    endfunction

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rs1_d = '0; rs2_d = '0; rs1_e = '0; rs2_e = '0; rd_e = '0; rd_m = '0;
        rd_w = '0; load_e = 0; regwr_m = 0; regwr_w = 0; taken_m = 0;
        mc_busy = 0; mc_start_e = 0;
        settle();
        // idle state: no bypass, no stall, no flush
        chk("R2 idle fwd_a", fwd_a_e, 0);
        chk("R5 idle stall", stall_f, 0);
        chk("R6 idle flush", flush_d | flush_e | flush_m, 0);

        // bypass sweep: R1 R2 R3
        for (int s = 0; s < NR; s++)
            for (int m = 0; m < NR; m++)
                for (int w = 0; w < NR; w++)
                    for (int en = 0; en < 4; en++) begin
                        rs1_e = AW'(s); rs2_e = AW'((s + 1) % NR);
                        rd_m = AW'(m); rd_w = AW'(w);
                        regwr_m = en[1]; regwr_w = en[0];
                        settle();
                        if (s == 0) chk("R3 x0 source", fwd_a_e, 0);
                        else if (exp_sel(s, m, en[1], w, en[0]) == 2)
                            chk("R1 mem bypass", fwd_a_e, 2);
                        else chk("R2 wb/rf bypass", fwd_a_e, exp_sel(s, m, en[1], w, en[0]));
                        chk("R1 operand b", fwd_b_e, exp_sel((s + 1) % NR, m, en[1], w, en[0]));
                    end

        // stall and flush sweep: R4..R9
        for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++)
                for (int d = 0; d < NR; d++)
                    for (int c = 0; c < 16; c++) begin
                        int lu, hold, fe;
                        rs1_d = AW'(a); rs2_d = AW'(b); rd_e = AW'(d);
                        load_e = c[0]; mc_busy = c[1]; taken_m = c[2]; mc_start_e = c[3];
                        settle();
                        lu = (c[0] && d != 0 && (d == a || d == b)) ? 1 : 0;
                        hold = ((lu != 0 || c[1]) && !c[2]) ? 1 : 0;
                        fe = (c[2] || (lu != 0 && !c[1])) ? 1 : 0;
                        chk("R4 R5 stall_f", stall_f, hold);
                        chk("R5 stall_d", stall_d, hold);
                        if (c[2]) begin
                            chk("R6 taken flush_d", flush_d, 1);
                            chk("R6 taken flush_e", flush_e, 1);
                            chk("R6 taken flush_m", flush_m, 1);
                            chk("R6 taken no stall", stall_f | stall_d, 0);
                        end else begin
                            chk("R7 flush_d", flush_d, 0);
                            chk("R7 flush_m", flush_m, 0);
                            if (c[1]) chk("R8 busy keeps exec", flush_e, 0);
                            else chk("R7 bubble flush_e", flush_e, lu);
                        end
                        chk("R9 gated start", mc_start_out, (c[3] && fe == 0) ? 1 : 0);
                    end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule